// File: doc/BRIEF.md
# Variable-Latency Register Access Controller

This block is the host-side register front end of a pattern-matching cell array. The host starts an access with a single-cycle strobe that carries a 4-bit address, a read/write flag and an 8-bit write value. The block decodes the access, drops `ready` and holds it low for a number of cycles chosen for that access. The choice depends on the register, on the operating mode (normal learn/recognize or save/restore) and on the array state at the moment the access is accepted. When the wait is over, `ready` rises and the read result appears on `rd_data`.

The block keeps the operating mode and the count of committed cells. The distance and category results come from array logic outside this block, through the `dist_value` and `cat_value` inputs. The `id_match` input tells the block whether a category access is the identifier case. `cell_commit` reports each newly committed cell.

Top module: `reg_access_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) drives `ready` high, `rd_data` to 0, the mode to normal and the committed count to 0.
- R2: An accepted access is held for L cycles. L is the number of rising edges after the accepting edge up to and including the edge at which `ready` rises. Unless R3 to R6 give another value, L is 1.
- R3: In normal mode, a write to address 0x2 takes 1 cycle when the committed count is 0 and 3 cycles otherwise.
- R4: In normal mode, a read of address 0x3 takes 18 cycles and returns `dist_value`. A write to address 0x3 takes 1 cycle.
- R5: In normal mode, a write to address 0x4 takes 1 cycle when `id_match` is high and 19 cycles otherwise. A read of 0x4 takes 3 cycles when `id_match` is high and 19 otherwise. The read returns `cat_value`.
- R6: A write to address 0xD loads the mode from bit 4 of the write value. 1 selects save/restore, so 0x10 enters it and 0x00 leaves it. A read of 0xD returns the mode in bit 4 and zeros elsewhere. In save/restore mode every access takes 1 cycle.
- R7: Each cycle with `cell_commit` high raises the committed count by one, saturating at 255. A read of address 0xF returns the count.
- R8: A write of 0x00 to address 0x9, or any write to address 0xF, clears the committed count to 0. A write of any other value to 0x9 leaves the count unchanged.
- R9: A strobe that arrives while `ready` is low is ignored: it starts no access and changes neither the mode nor the count.
- R10: `rd_data` is loaded on the edge at which `ready` rises and then holds until the next completion. Write accesses, and reads of addresses other than 0x3, 0x4, 0xD and 0xF, load 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_strobe | input | 1 | Access request, sampled while ready is high |
| acc_addr | input | 4 | Register address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write value |
| cell_commit | input | 1 | One cell became committed this cycle |
| id_match | input | 1 | Category access is the identifier case |
| dist_value | input | 16 | Distance result from the array |
| cat_value | input | 16 | Category result from the array |
| ready | output | 1 | High when idle; low while an access is in progress |
| rd_data | output | 16 | Result of the last completed access |

## Verification
The assertions assume that `id_match` and the committed count are meaningful only at the accepting edge. They also assume that `dist_value` and `cat_value` are sampled only at the completing edge. The stimulus therefore sets those inputs before each strobe and holds them until `ready` has risen. The latency check assumes `acc_strobe` is a clean level at each edge. The bench drives all inputs at falling edges only, and it raises strobes during busy windows on purpose, to exercise the ignore rule. Commit pulses are given both while idle and while busy, so the count update is exercised with and without an access in progress.

// File: rtl/rac_pkg.sv
// Package: shared constants and types for the register access controller.
// Assumes a 4-bit register address space.
package rac_pkg;

    localparam logic [3:0] ADR_LAST_COMP = 4'h2;
    localparam logic [3:0] ADR_DIST      = 4'h3;
    localparam logic [3:0] ADR_CATEGORY  = 4'h4;
    localparam logic [3:0] ADR_TEST_CAT  = 4'h9;
    localparam logic [3:0] ADR_STATUS    = 4'hD;
    localparam logic [3:0] ADR_COUNT     = 4'hF;

    localparam int MODE_BIT = 4;

    typedef struct packed {
        logic [3:0] addr;
        logic       wr;
    } acc_t;

    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_DIST,
        SRC_CAT,
        SRC_COUNT,
        SRC_STATUS
    } rd_src_e;

endpackage

// File: rtl/rac_access_decode.sv
// Access decoder: picks the hold latency and the read source for one access.
// Assumes the inputs are sampled by the caller at the accepting edge;
// never returns a latency of zero.
module rac_access_decode
    import rac_pkg::*;
#(
    parameter int LAT_W         = 5,
    parameter int LCOMP_LAT     = 3,
    parameter int DIST_LAT      = 18,
    parameter int CAT_LAT       = 19,
    parameter int CAT_ID_RD_LAT = 3
) (
    input  acc_t             acc,
    input  logic             sr_mode,
    input  logic             any_committed,
    input  logic             id_case,
    output logic [LAT_W-1:0] lat,
    output rd_src_e          rd_src
);

    // Purpose: latency from register, direction, mode and array state.
    always_comb begin
        lat = LAT_W'(1);
        if (!sr_mode) begin
            unique case (acc.addr)
                ADR_LAST_COMP: if (acc.wr && any_committed) lat = LAT_W'(LCOMP_LAT);
                ADR_DIST:      if (!acc.wr) lat = LAT_W'(DIST_LAT);
                ADR_CATEGORY: begin
                    if (acc.wr) lat = id_case ? LAT_W'(1) : LAT_W'(CAT_LAT);
                    else        lat = id_case ? LAT_W'(CAT_ID_RD_LAT) : LAT_W'(CAT_LAT);
                end
                default: lat = LAT_W'(1);
            endcase
        end
    end

    // Purpose: which value a read loads into the output register.
    always_comb begin
        rd_src = SRC_ZERO;
        if (!acc.wr) begin
            unique case (acc.addr)
                ADR_DIST:     rd_src = SRC_DIST;
                ADR_CATEGORY: rd_src = SRC_CAT;
                ADR_COUNT:    rd_src = SRC_COUNT;
                ADR_STATUS:   rd_src = SRC_STATUS;
                default:      rd_src = SRC_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/rac_state_regs.sv
// State registers: operating mode bit and saturating committed-cell count.
// Assumes 'accept' is high only on the edge that takes an access.
module rac_state_regs
    import rac_pkg::*;
#(
    parameter int WD_W  = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  acc_t             acc,
    input  logic [WD_W-1:0]  wdata,
    input  logic             cell_commit,
    output logic             sr_mode,
    output logic [CNT_W-1:0] ncount
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic clear_cnt;

    // Purpose: detect the two commands that uncommit all cells.
    always_comb begin
        clear_cnt = accept && acc.wr &&
                    ((acc.addr == ADR_TEST_CAT && wdata == '0) || acc.addr == ADR_COUNT);
    end

    // Purpose: mode register, loaded by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        sr_mode <= 1'b0;
        else if (accept && acc.wr && acc.addr == ADR_STATUS) sr_mode <= wdata[MODE_BIT];
    end

    // Purpose: committed count; clearing wins over a commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 ncount <= '0;
        else if (clear_cnt)                         ncount <= '0;
        else if (cell_commit && ncount != CNT_MAX)  ncount <= ncount + 1'b1;
    end

endmodule

// File: rtl/rac_busy_timer.sv
// Busy timer: drops ready for 'lat' cycles after a start while idle.
// Assumes lat >= 1; starts while busy are ignored.
module rac_busy_timer #(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    output logic             ready,
    output logic             finish
);

    logic [LAT_W-1:0] remain;

    // Purpose: count down the remaining hold cycles and raise ready at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready  <= 1'b1;
            remain <= '0;
        end else if (ready && start) begin
            ready  <= 1'b0;
            remain <= lat - 1'b1;
        end else if (!ready) begin
            if (remain == '0) ready  <= 1'b1;
            else              remain <= remain - 1'b1;
        end
    end

    // Purpose: flag the edge on which the access completes.
    assign finish = !ready && (remain == '0);

endmodule

// File: rtl/reg_access_ctrl.sv
// Top: register access controller with per-access variable latency.
// Accepts a strobe only while ready is high, holds ready low for the decoded
// latency and loads rd_data on the completing edge. Assumes the array inputs
// are stable around the accepting and completing edges.
module reg_access_ctrl
    import rac_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int WD_W          = 8,
    parameter int CNT_W         = 8,
    parameter int MAX_LAT       = 31,
    parameter int LCOMP_LAT     = 3,
    parameter int DIST_LAT      = 18,
    parameter int CAT_LAT       = 19,
    parameter int CAT_ID_RD_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_strobe,
    input  logic [3:0]        acc_addr,
    input  logic              acc_write,
    input  logic [WD_W-1:0]   acc_wdata,
    input  logic              cell_commit,
    input  logic              id_match,
    input  logic [DATA_W-1:0] dist_value,
    input  logic [DATA_W-1:0] cat_value,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data
);

    localparam int LAT_W = $clog2(MAX_LAT + 1);

    acc_t             acc;
    logic             accept;
    logic             finish;
    logic             sr_mode;
    logic [CNT_W-1:0] ncount;
    logic [LAT_W-1:0] lat;
    rd_src_e          src_now;
    rd_src_e          src_q;
    logic [WD_W-1:0]  status_vec;
    logic [DATA_W-1:0] rd_next;

    assign acc    = '{addr: acc_addr, wr: acc_write};
    assign accept = ready && acc_strobe;

    rac_access_decode #(
        .LAT_W(LAT_W), .LCOMP_LAT(LCOMP_LAT), .DIST_LAT(DIST_LAT),
        .CAT_LAT(CAT_LAT), .CAT_ID_RD_LAT(CAT_ID_RD_LAT)
    ) u_decode (
        .acc(acc), .sr_mode(sr_mode), .any_committed(ncount != '0),
        .id_case(id_match), .lat(lat), .rd_src(src_now)
    );

    rac_state_regs #(.WD_W(WD_W), .CNT_W(CNT_W)) u_state (
        .clk(clk), .rst_n(rst_n), .accept(accept), .acc(acc), .wdata(acc_wdata),
        .cell_commit(cell_commit), .sr_mode(sr_mode), .ncount(ncount)
    );

    rac_busy_timer #(.LAT_W(LAT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(acc_strobe), .lat(lat),
        .ready(ready), .finish(finish)
    );

    // Purpose: remember the read source of the access in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)      src_q <= SRC_ZERO;
        else if (accept) src_q <= src_now;
    end

    // Purpose: form the status value with the mode in its bit.
    always_comb begin
        status_vec           = '0;
        status_vec[MODE_BIT] = sr_mode;
    end

    // Purpose: select the value loaded at completion.
    always_comb begin
        unique case (src_q)
            SRC_DIST:   rd_next = dist_value;
            SRC_CAT:    rd_next = cat_value;
            SRC_COUNT:  rd_next = DATA_W'(ncount);
            SRC_STATUS: rd_next = DATA_W'(status_vec);
            default:    rd_next = '0;
        endcase
    end

    // Purpose: output data register, loaded only when ready rises.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (finish) rd_data <= rd_next;
    end

endmodule

// File: rtl/rac_checker.sv
// Checker: protocol and latency properties of reg_access_ctrl.
// Assumes rst_n is held low for at least two edges at start-up.
module rac_checker #(
    parameter int DATA_W        = 16,
    parameter int CNT_W         = 8,
    parameter int LCOMP_LAT     = 3,
    parameter int DIST_LAT      = 18,
    parameter int CAT_LAT       = 19,
    parameter int CAT_ID_RD_LAT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_strobe,
    input logic [3:0]        acc_addr,
    input logic              acc_write,
    input logic              id_match,
    input logic              ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              sr_mode,
    input logic [CNT_W-1:0]  ncount
);

    int busy_len;
    int want_len;

    // Purpose: measure the hold time and note the expected one at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= 0;
            want_len <= 1;
        end else if (ready && acc_strobe) begin
            busy_len <= 0;
            if (sr_mode)                                    want_len <= 1;
            else if (acc_addr == 4'h2 && acc_write)         want_len <= (ncount == '0) ? 1 : LCOMP_LAT;
            else if (acc_addr == 4'h3 && !acc_write)        want_len <= DIST_LAT;
            else if (acc_addr == 4'h4 && acc_write)         want_len <= id_match ? 1 : CAT_LAT;
            else if (acc_addr == 4'h4)                      want_len <= id_match ? CAT_ID_RD_LAT : CAT_LAT;
            else                                            want_len <= 1;
        end else if (!ready) begin
            busy_len <= busy_len + 1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ready && rd_data == '0 && !sr_mode && ncount == '0)); // R1

    AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && acc_strobe) |=> !ready); // R2

    AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (busy_len == want_len)); // R5

    AST_SR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_mode && ready && acc_strobe) |=> ##1 ready); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ncount != $past(ncount)) |-> (ncount == '0 || ncount == CNT_W'($past(ncount) + 1'b1))); // R7

    AST_FORGET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && acc_strobe && acc_write && acc_addr == 4'hF) |=> (ncount == '0)); // R8

    AST_BUSY_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(sr_mode)); // R9

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ready) |-> $stable(rd_data)); // R10

endmodule

bind reg_access_ctrl rac_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .LCOMP_LAT(LCOMP_LAT),
    .DIST_LAT(DIST_LAT), .CAT_LAT(CAT_LAT), .CAT_ID_RD_LAT(CAT_ID_RD_LAT)
) u_rac_checker (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
    .acc_write(acc_write), .id_match(id_match), .ready(ready), .rd_data(rd_data),
    .sr_mode(sr_mode), .ncount(ncount)
);

// File: tb/reg_access_ctrl_tb_top.sv
module reg_access_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_strobe = 1'b0;
    logic [3:0]  acc_addr = 4'h0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_wdata = 8'h00;
    logic        cell_commit = 1'b0;
    logic        id_match = 1'b0;
    logic [15:0] dist_value = 16'h0000;
    logic [15:0] cat_value = 16'h0000;
    logic        ready;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    reg_access_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .cell_commit(cell_commit),
        .id_match(id_match), .dist_value(dist_value), .cat_value(cat_value),
        .ready(ready), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit          m_rdy = 1;
    int          m_rem = 0;
    logic [15:0] m_rd = 16'h0;
    bit          m_sr = 0;
    int          m_cnt = 0;
    logic [3:0]  m_addr = 4'h0;
    bit          m_wr = 0;
    bit          m_clr = 0;

    function automatic int ref_lat(input logic [3:0] a, input bit w);
        if (m_sr) return 1;
        if (a == 4'h2 && w)  return (m_cnt == 0) ? 1 : 3;
        if (a == 4'h3 && !w) return 18;
        if (a == 4'h4 && w)  return id_match ? 1 : 19;
        if (a == 4'h4)       return id_match ? 3 : 19;
        return 1;
    endfunction

    function automatic logic [15:0] ref_read();
        if (m_wr) return 16'h0;
        case (m_addr)
            4'h3:    return dist_value;
            4'h4:    return cat_value;
            4'hD:    return m_sr ? 16'h0010 : 16'h0000;
            4'hF:    return 16'(m_cnt);
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        m_clr = 0;
        if (!rst_n) begin
            m_rdy = 1; m_rem = 0; m_rd = 16'h0; m_sr = 0; m_cnt = 0;
        end else begin
            if (m_rdy && acc_strobe) begin
                m_rdy  = 0;
                m_rem  = ref_lat(acc_addr, acc_write);
                m_addr = acc_addr;
                m_wr   = acc_write;
                if (acc_write && acc_addr == 4'hD) m_sr = acc_wdata[4];
                if (acc_write && (acc_addr == 4'hF || (acc_addr == 4'h9 && acc_wdata == 8'h00)))
                    m_clr = 1;
            end else if (!m_rdy) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_rdy = 1;
                    m_rd  = ref_read();
                end
            end
            if (m_clr) m_cnt = 0;
            else if (cell_commit && m_cnt < 255) m_cnt++;
        end
    end

    // Per-clock comparison against the model (R9, R10)
    always @(negedge clk) begin
        if (started && !done) begin
            chk(ready == m_rdy, "R9 ready vs model", longint'(ready), longint'(m_rdy));
            chk(rd_data == m_rd, "R10 rd_data vs model", longint'(rd_data), longint'(m_rd));
        end
    end

    task automatic access(input logic [3:0] a, input bit w, input logic [7:0] d,
                          input int exp_lat, input string tag);
        int n = 0;
        @(negedge clk);
        acc_strobe = 1'b1; acc_addr = a; acc_write = w; acc_wdata = d;
        @(negedge clk);
        acc_strobe = 1'b0;
        while (!ready) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_lat, tag, longint'(n), longint'(exp_lat));
    endtask

    task automatic commit_pulses(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); cell_commit = 1'b1;
        end
        @(negedge clk); cell_commit = 1'b0;
    endtask

    task automatic summary();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        started = 1;
        // R1: reset state
        chk(ready == 1'b1, "R1 ready in reset", longint'(ready), 1);
        chk(rd_data == 16'h0, "R1 rd_data in reset", longint'(rd_data), 0);
        rst_n = 1'b1;
        access(4'hD, 0, 8'h00, 1, "R1 mode read latency");
        chk(rd_data == 16'h0, "R1 mode normal after reset", longint'(rd_data), 0);
        access(4'hF, 0, 8'h00, 1, "R1 count read latency");
        chk(rd_data == 16'h0, "R1 count zero after reset", longint'(rd_data), 0);

        // R2: default single-cycle accesses
        access(4'h1, 0, 8'h00, 1, "R2 read 0x1");
        access(4'h5, 1, 8'h3C, 1, "R2 write 0x5");
        access(4'hA, 0, 8'h00, 1, "R2 read 0xA");

        // R3: last-component write
        access(4'h2, 1, 8'h11, 1, "R3 no committed cells");
        commit_pulses(2);
        access(4'hF, 0, 8'h00, 1, "R7 count read latency");
        chk(rd_data == 16'd2, "R7 count after two commits", longint'(rd_data), 2);
        access(4'h2, 1, 8'h22, 3, "R3 committed cells");

        // R4: distance
        dist_value = 16'h1234;
        access(4'h3, 0, 8'h00, 18, "R4 distance read");
        chk(rd_data == 16'h1234, "R4 distance value", longint'(rd_data), 16'h1234);
        access(4'h3, 1, 8'h07, 1, "R4 index write");
        chk(rd_data == 16'h0, "R10 write loads zero", longint'(rd_data), 0);

        // R10: data holds while idle even if the source moves
        access(4'h3, 0, 8'h00, 18, "R4 distance read again");
        dist_value = 16'hBEEF;
        repeat (5) @(negedge clk);
        chk(rd_data == 16'h1234, "R10 held while idle", longint'(rd_data), 16'h1234);

        // R5: category
        cat_value = 16'h00A5;
        id_match = 1'b1;
        access(4'h4, 1, 8'h05, 1, "R5 cat write id");
        access(4'h4, 0, 8'h00, 3, "R5 cat read id");
        chk(rd_data == 16'h00A5, "R5 cat value", longint'(rd_data), 16'h00A5);
        id_match = 1'b0;
        access(4'h4, 1, 8'h05, 19, "R5 cat write no id");
        cat_value = 16'h0C3E;
        access(4'h4, 0, 8'h00, 19, "R5 cat read no id");
        chk(rd_data == 16'h0C3E, "R5 cat value no id", longint'(rd_data), 16'h0C3E);

        // R9: strobe during busy is ignored
        @(negedge clk);
        acc_strobe = 1'b1; acc_addr = 4'h3; acc_write = 1'b0;
        @(negedge clk);
        acc_strobe = 1'b0;
        repeat (2) @(negedge clk);
        acc_strobe = 1'b1; acc_addr = 4'hF; acc_write = 1'b1; acc_wdata = 8'h10;
        repeat (4) @(negedge clk);
        acc_addr = 4'hD;
        repeat (4) @(negedge clk);
        acc_strobe = 1'b0;
        while (!ready) @(negedge clk);
        access(4'hD, 0, 8'h00, 1, "R9 mode read latency");
        chk(rd_data == 16'h0, "R9 mode unchanged by busy strobe", longint'(rd_data), 0);
        access(4'hF, 0, 8'h00, 1, "R9 count read latency");
        chk(rd_data == 16'd2, "R9 count unchanged by busy strobe", longint'(rd_data), 2);

        // R6: save/restore mode
        access(4'hD, 1, 8'h10, 1, "R6 enter save/restore");
        access(4'hD, 0, 8'h00, 1, "R6 status read");
        chk(rd_data == 16'h0010, "R6 mode bit set", longint'(rd_data), 16'h10);
        access(4'h3, 0, 8'h00, 1, "R6 distance read");
        chk(rd_data == 16'hBEEF, "R6 distance value", longint'(rd_data), 16'hBEEF);
        access(4'h4, 1, 8'h01, 1, "R6 cat write");
        access(4'h4, 0, 8'h00, 1, "R6 cat read");
        access(4'h2, 1, 8'h01, 1, "R6 last comp write");
        access(4'h1, 1, 8'h01, 1, "R6 comp write");
        access(4'hD, 1, 8'h00, 1, "R6 leave save/restore");
        access(4'h3, 0, 8'h00, 18, "R6 normal again");

        // R8: clearing the count
        access(4'h9, 1, 8'h05, 1, "R8 testcat nonzero");
        access(4'hF, 0, 8'h00, 1, "R8 count read");
        chk(rd_data == 16'd2, "R8 nonzero keeps count", longint'(rd_data), 2);
        access(4'h9, 1, 8'h00, 1, "R8 testcat zero");
        access(4'hF, 0, 8'h00, 1, "R8 count read");
        chk(rd_data == 16'd0, "R8 zero write clears", longint'(rd_data), 0);
        access(4'h2, 1, 8'h00, 1, "R3 after clear");
        commit_pulses(3);
        access(4'hF, 1, 8'hAA, 1, "R8 forget write");
        access(4'hF, 0, 8'h00, 1, "R8 count read");
        chk(rd_data == 16'd0, "R8 forget clears", longint'(rd_data), 0);

        // R7: saturation
        commit_pulses(300);
        access(4'hF, 0, 8'h00, 1, "R7 count read");
        chk(rd_data == 16'd255, "R7 count saturates", longint'(rd_data), 255);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule